// File: doc/BRIEF.md
# Core/DMA Round-Robin Bus Arbiter

This block decides which of two requesters owns a shared internal bus: a processor core, or a DMA module with several channels. The decision runs in two stages. First, the DMA side chooses one pending channel by a fixed priority that comes from a per-channel priority code. Then a core-versus-DMA stage grants the bus to one side. In round-robin mode the two sides alternate while both keep asking. Because the DMA module competes as a single requester, the core gets the bus back after any DMA transfer, even when other DMA channels are still waiting.

A grant is registered and held until the owner strobes transfer completion. The arbiter re-decides on the cycle of that strobe, or on any cycle when the bus has no owner. The new grant appears on the following clock edge. A 2-bit mode input selects the scheme. Round-robin is the only scheme that is fully modelled. Every other mode value gives the core a fixed preference over the DMA module.

Top module: `bus_arb_top`

## Requirements
- R1: After reset both grant bits are 0. The first decision with both sides requesting goes to the core.
- R2: Among the DMA channels that are requesting, the one whose 3-bit priority code is numerically lowest wins. Its index appears on `grant_chan` while `grant[1]` is 1.
- R3: When requesting channels carry equal codes, the lower-numbered channel wins.
- R4: `grant` is `01` for the core, `10` for DMA, or `00`. It is never `11`.
- R5: A decision slot is a cycle in which the bus has no owner or `xfer_done` is 1. Outside a decision slot, `grant` and `grant_chan` keep their values, whatever the requests do.
- R6: When only one side requests at a decision slot, that side is granted on the next edge, regardless of history.
- R7: With `park_mode` = `00` and both sides requesting at every decision slot, the grant alternates between core and DMA.
- R8: If the core requests at the decision slot that ends a DMA transfer, the core is granted next, even if DMA channels are still pending.
- R9: With `park_mode` other than `00`, the core wins every decision slot at which it requests.
- R10: A decision slot with no request at all leaves `grant` at `00` on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| core_req | input | 1 | Core bus request |
| dma_req | input | 4 | Per-channel DMA requests |
| dma_prio | input | 12 | Packed 3-bit priority codes, channel n at bits [3n+2:3n]; lower is more urgent |
| xfer_done | input | 1 | Current transfer completes this cycle |
| park_mode | input | 2 | Scheme select; 00 = round-robin, others = core-first |
| grant | output | 2 | Bit 0 core granted, bit 1 DMA granted |
| grant_chan | output | 2 | Index of the granted DMA channel |

## Verification
The bench targets the case where the core requests while a DMA transfer is running and a second channel is still waiting. A design that rotated through the DMA channels would hand the bus to that channel instead of the core. It also drives tied priority codes, where a wrong tie-break picks the higher index. It changes codes and requests during a held grant, where a design that re-arbitrates without a decision slot would move the grant or the channel index. Finally, it repeats decisions in core-first mode, where a design that alternated regardless of mode would hand the bus to DMA.

// File: rtl/bus_arb_pkg.sv
package bus_arb_pkg;

  typedef enum logic [1:0] {
    OWN_NONE = 2'b00,
    OWN_CORE = 2'b01,
    OWN_DMA  = 2'b10
  } owner_e;

  localparam logic [1:0] MODE_ALTERNATE = 2'b00;

  // Core-versus-DMA decision at a decision slot.
  function automatic owner_e side_pick(input logic core_req,
                                       input logic dma_any,
                                       input logic alternate,
                                       input logic last_was_dma);
    owner_e res;
    if (core_req && dma_any) begin
      if (alternate) res = last_was_dma ? OWN_CORE : OWN_DMA;
      else           res = OWN_CORE;
    end else if (core_req) begin
      res = OWN_CORE;
    end else if (dma_any) begin
      res = OWN_DMA;
    end else begin
      res = OWN_NONE;
    end
    return res;
  endfunction

endpackage

// File: rtl/dma_prio_sel.sv
module dma_prio_sel #(
  parameter int NCH = 4,
  parameter int PW  = 3,
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [NCH-1:0]    req,
  input  logic [NCH*PW-1:0] prio,
  output logic              any,
  output logic [IW-1:0]     win_idx
);

  logic [PW-1:0] code [NCH];

  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : g_unpack
      assign code[g] = prio[g*PW +: PW];
    end
  endgenerate

  logic [PW-1:0] best;

  always_comb begin
    any     = 1'b0;
    win_idx = '0;
    best    = '1;
    for (int i = 0; i < NCH; i++) begin
      // strict compare keeps the lower index on a tie
      if (req[i] && (!any || (code[i] < best))) begin
        any     = 1'b1;
        best    = code[i];
        win_idx = IW'(i);
      end
    end
  end

endmodule

// File: rtl/side_select.sv
module side_select
  import bus_arb_pkg::*;
(
  input  logic   core_req,
  input  logic   dma_any,
  input  logic   alternate,
  input  logic   last_was_dma,
  output owner_e pick
);

  assign pick = side_pick(core_req, dma_any, alternate, last_was_dma);

endmodule

// File: rtl/grant_reg.sv
module grant_reg
  import bus_arb_pkg::*;
#(
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arb_slot,
  input  owner_e        pick,
  input  logic [IW-1:0] win_idx,
  output owner_e        owner,
  output logic [IW-1:0] chan,
  output logic          last_was_dma
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner        <= OWN_NONE;
      chan         <= '0;
      last_was_dma <= 1'b1;   // core gets first turn
    end else if (arb_slot) begin
      owner <= pick;
      if (pick == OWN_DMA) begin
        chan         <= win_idx;
        last_was_dma <= 1'b1;
      end else if (pick == OWN_CORE) begin
        last_was_dma <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/bus_arb_top.sv
module bus_arb_top
  import bus_arb_pkg::*;
#(
  parameter int NCH = 4,
  parameter int PW  = 3,
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              core_req,
  input  logic [NCH-1:0]    dma_req,
  input  logic [NCH*PW-1:0] dma_prio,
  input  logic              xfer_done,
  input  logic [1:0]        park_mode,
  output logic [1:0]        grant,
  output logic [IW-1:0]     grant_chan
);

  logic          dma_any;
  logic [IW-1:0] win_idx;
  logic          alternate;
  logic          arb_slot;
  logic          last_was_dma;
  owner_e        pick;
  owner_e        owner;

  assign alternate = (park_mode == MODE_ALTERNATE);
  assign arb_slot  = (owner == OWN_NONE) || xfer_done;

  dma_prio_sel #(.NCH(NCH), .PW(PW)) u_dma_sel (
    .req     (dma_req),
    .prio    (dma_prio),
    .any     (dma_any),
    .win_idx (win_idx)
  );

  side_select u_side (
    .core_req     (core_req),
    .dma_any      (dma_any),
    .alternate    (alternate),
    .last_was_dma (last_was_dma),
    .pick         (pick)
  );

  grant_reg #(.IW(IW)) u_grant (
    .clk          (clk),
    .rst_n        (rst_n),
    .arb_slot     (arb_slot),
    .pick         (pick),
    .win_idx      (win_idx),
    .owner        (owner),
    .chan         (grant_chan),
    .last_was_dma (last_was_dma)
  );

  assign grant = owner;

endmodule

// File: rtl/bus_arb_chk.sv
module bus_arb_chk #(
  parameter int NCH = 4,
  parameter int IW  = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           core_req,
  input logic [NCH-1:0] dma_req,
  input logic           xfer_done,
  input logic [1:0]     park_mode,
  input logic           arb_slot,
  input logic [1:0]     grant,
  input logic [IW-1:0]  grant_chan
);

  p_grant_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  p_hold_grant_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != 2'b00 && !xfer_done) |=> $stable(grant));

  p_hold_chan_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (grant == 2'b10 && !xfer_done) |=> $stable(grant_chan));

  p_core_alone_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_slot && core_req && dma_req == '0) |=> grant == 2'b01);

  p_dma_alone_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_slot && !core_req && dma_req != '0) |=> grant == 2'b10);

  p_core_after_dma_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (grant == 2'b10 && xfer_done && core_req) |=> grant == 2'b01);

  p_core_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_slot && core_req && park_mode != 2'b00) |=> grant == 2'b01);

  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_slot && !core_req && dma_req == '0) |=> grant == 2'b00);

endmodule

bind bus_arb_top bus_arb_chk #(.NCH(NCH), .IW(IW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .core_req   (core_req),
  .dma_req    (dma_req),
  .xfer_done  (xfer_done),
  .park_mode  (park_mode),
  .arb_slot   (arb_slot),
  .grant      (grant),
  .grant_chan (grant_chan)
);

// File: tb/test_bus_arb_top.sv
module test_bus_arb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        core_req = 1'b0;
  logic [3:0]  dma_req = '0;
  logic [11:0] dma_prio = '0;
  logic        xfer_done = 1'b0;
  logic [1:0]  park_mode = 2'b00;
  logic [1:0]  grant;
  logic [1:0]  grant_chan;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [1:0] g;
    logic [1:0] ch;
    string      tag;
  } item_t;

  item_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_arb_top i_bus_arb_top (
    .clk(clk), .rst_n(rst_n), .core_req(core_req), .dma_req(dma_req),
    .dma_prio(dma_prio), .xfer_done(xfer_done), .park_mode(park_mode),
    .grant(grant), .grant_chan(grant_chan)
  );

  function automatic logic [11:0] codes(input logic [2:0] c0, input logic [2:0] c1,
                                        input logic [2:0] c2, input logic [2:0] c3);
    return {c3, c2, c1, c0};
  endfunction

  // Driver: apply one cycle of stimulus and queue the grant expected after the edge.
  task automatic step(input logic c, input logic [3:0] r, input logic [11:0] p,
                      input logic d, input logic [1:0] m,
                      input logic [1:0] eg, input logic [1:0] ech, input string tag);
    item_t it;
    @(negedge clk);
    core_req = c; dma_req = r; dma_prio = p; xfer_done = d; park_mode = m;
    it.g = eg; it.ch = ech; it.tag = tag;
    exp_q.push_back(it);
  endtask

  // Monitor: compare away from the edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        item_t it;
        it = exp_q.pop_front();
        checks++;
        if (grant != it.g) begin
          errors++;
          $display("FAIL %s grant actual %b expected %b", it.tag, grant, it.g);
        end
        checks++;
        if (grant == 2'b11) begin
          errors++;
          $display("FAIL R4 grant actual %b expected one-hot or zero", grant);
        end
        if (it.g == 2'b10) begin
          checks++;
          if (grant_chan != it.ch) begin
            errors++;
            $display("FAIL %s channel actual %0d expected %0d", it.tag, grant_chan, it.ch);
          end
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [11:0] p_tie;
    logic [11:0] p_ch1;
    p_tie = codes(3'b010, 3'b010, 3'b111, 3'b111);
    p_ch1 = codes(3'b010, 3'b001, 3'b111, 3'b111);
    repeat (3) @(negedge clk);
    checks++;
    if (grant != 2'b00) begin
      errors++;
      $display("FAIL R1 reset grant actual %b expected 00", grant);
    end
    rst_n = 1'b1;
    step(0, 4'b0000, p_tie, 0, 2'b00, 2'b00, 2'd0, "R10 idle");
    step(1, 4'b0011, p_tie, 0, 2'b00, 2'b01, 2'd0, "R1 core first");
    step(1, 4'b0011, p_tie, 0, 2'b00, 2'b01, 2'd0, "R5 core held");
    step(1, 4'b0011, p_tie, 1, 2'b00, 2'b10, 2'd0, "R3 tie to ch0");
    step(1, 4'b0011, p_ch1, 0, 2'b00, 2'b10, 2'd0, "R5 chan held");
    step(1, 4'b0010, p_ch1, 1, 2'b00, 2'b01, 2'd0, "R8 core after dma");
    step(0, 4'b0011, p_ch1, 1, 2'b00, 2'b10, 2'd1, "R2 lowest code ch1");
    step(1, 4'b0011, p_ch1, 1, 2'b00, 2'b01, 2'd0, "R7 alternate core");
    step(1, 4'b0011, p_ch1, 1, 2'b00, 2'b10, 2'd1, "R7 alternate dma");
    step(1, 4'b0011, p_ch1, 1, 2'b01, 2'b01, 2'd0, "R9 core first a");
    step(1, 4'b0011, p_ch1, 1, 2'b01, 2'b01, 2'd0, "R9 core first b");
    step(0, 4'b1000, p_ch1, 1, 2'b01, 2'b10, 2'd3, "R6 dma alone");
    step(0, 4'b0000, p_ch1, 1, 2'b00, 2'b00, 2'd0, "R10 none");
    step(0, 4'b1101, codes(3'b111, 3'b000, 3'b000, 3'b000), 0, 2'b00, 2'b10, 2'd2, "R3 tie ch2");
    step(0, 4'b0000, p_ch1, 0, 2'b00, 2'b10, 2'd2, "R5 held without req");
    step(0, 4'b0000, p_ch1, 1, 2'b00, 2'b00, 2'd0, "R10 release");
    step(1, 4'b0000, p_ch1, 0, 2'b00, 2'b01, 2'd0, "R6 core alone");
    step(0, 4'b0000, p_ch1, 1, 2'b00, 2'b00, 2'd0, "R10 end");
    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule